// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This controller gathers event pulses from a group of peripheral sources and turns them into interrupt entries for a small processor model. Each source owns a sticky request flag, an enable bit and a priority bit. A source that is both flagged and enabled is pending. When the global enable for its level is on and the pending state has lasted a fixed number of cycles, the controller raises a one-cycle take strobe with a fixed vector. It then saves the processor's current address on an internal return stack.

There are two levels, each with its own global enable. A high-priority request can break into a running low-priority handler. A low-priority request waits while any high-priority handler is in service. A return command pops the saved address, hands it back to the processor and turns the global enable of the popped level back on. Flags, enables, priorities and the two global enables are reached through a small register port with four addresses.

Top module: `irq_vector_ctrl`

## Requirements
- R1: An event pulse on `evt_i[i]` sets flag i whether or not enable i is set. Flags read at address 0, enables at address 1, priorities at address 2 (bit = 1 means high). Global enables read at address 3, with bit 1 for high and bit 0 for low.
- R2: A write to address 0 can only clear flags: a 0 in bit i clears flag i and a 1 leaves it unchanged. If an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R3: `pend_o` equals flags AND enables. A level can be taken only when one of its sources is pending and that level's global enable is 1. A flagged source with enable 0 never causes a take.
- R4: `vec_o` is 0x0008 for a high take and 0x0018 for a low take. These come from 0x0008 OR (inverted priority << 4).
- R5: Reset clears all flags, enables, priorities and global enables and empties the stack. In the first cycle after reset, `boot_o` is 1, `vec_o` is 0x0000 and `take_o` is 0.
- R6: If a request stays qualified from the cycle its flag becomes visible, `take_o` rises LATENCY (default 2) clock edges later.
- R7: A take lasts one cycle. It clears the global enable of the level taken and pushes `pc_i` together with that level onto the return stack.
- R8: A high request is taken even while a low handler is in service. A low request is not taken while a high handler is in service. When both levels are ready, the high level wins.
- R9: `reti_i` with a non-empty stack pops the top entry. In the next cycle `ret_o` is 1 and `ret_pc_o` holds the saved address. The global enable of the popped level is set. `reti_i` with an empty stack has no effect. No take occurs in a cycle where `reti_i` is 1.
- R10: The stack holds STK_DEPTH (default 32) entries of PC_W (default 21) bits. While it is full, no take occurs and the global enables are left as they are.
- R11: Several sources pending together at one level produce a single take, and `pend_o` lists all of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC | One-cycle event pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 flags, 1 enables, 2 priorities, 3 global enables |
| reg_wdata | input | N_SRC | Write data |
| reg_rdata | output | N_SRC | Read data for `reg_addr`, combinational |
| pc_i | input | PC_W | Current processor address, saved on a take |
| reti_i | input | 1 | Return-from-interrupt command |
| boot_o | output | 1 | High for the first cycle after reset |
| take_o | output | 1 | Take-interrupt strobe |
| vec_o | output | PC_W | Vector address, valid with `take_o` or `boot_o` |
| ret_o | output | 1 | Return strobe, one cycle after an accepted `reti_i` |
| ret_pc_o | output | PC_W | Restored address, valid with `ret_o` |
| pend_o | output | N_SRC | Pending enabled sources |

## Verification
The in-line properties assume that `evt_i`, `reg_we` and `reti_i` change only between clock edges and are never X after reset. They also assume the processor issues `reti_i` only for handlers it has entered. The bench drives every input on the falling edge and samples a little later. Returns are issued only in matched pairs with takes, apart from one deliberate return on an empty stack. The full-stack case is reached by re-enabling the low level inside each handler rather than by forcing internal state.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_SRC     = 8,
  parameter int PC_W      = 21,
  parameter int STK_DEPTH = 32,
  parameter int LATENCY   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             reti_i,
  output logic             boot_o,
  output logic             take_o,
  output logic [PC_W-1:0]  vec_o,
  output logic             ret_o,
  output logic [PC_W-1:0]  ret_pc_o,
  output logic [N_SRC-1:0] pend_o
);
  localparam int AW  = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;
  localparam int SPW = $clog2(STK_DEPTH + 1);
  localparam int EW  = PC_W + 1;

  logic [N_SRC-1:0]   flags, en, pri;
  logic               gie_h, gie_l, boot_q, ret_q;
  logic [LATENCY-1:0] sr_h, sr_l;
  logic [EW-1:0]      stk [STK_DEPTH];
  logic [SPW-1:0]     sp, act_hi;
  logic [PC_W-1:0]    ret_pc_q;

  wire wr_flag = reg_we && reg_addr == 2'd0;
  wire wr_en   = reg_we && reg_addr == 2'd1;
  wire wr_pri  = reg_we && reg_addr == 2'd2;
  wire wr_gie  = reg_we && reg_addr == 2'd3;

  wire full  = sp == SPW'(STK_DEPTH);
  wire empty = sp == '0;

  assign pend_o = flags & en;
  wire any_h = |(pend_o & pri);
  wire any_l = |(pend_o & ~pri);

  wire req_h  = gie_h && any_h && !full && !reti_i;
  wire req_l  = gie_l && any_l && act_hi == '0 && !full && !reti_i;
  wire fire_h = req_h && (&sr_h);
  wire fire_l = req_l && (&sr_l) && !fire_h;

  assign take_o = fire_h || fire_l;
  assign vec_o  = take_o ? (PC_W'(8) | (PC_W'(!fire_h) << 4)) : '0;
  assign boot_o = boot_q;
  assign ret_o  = ret_q;
  assign ret_pc_o = ret_pc_q;

  wire            pop     = reti_i && !empty;
  wire [AW-1:0]   top_idx = AW'(sp - SPW'(1));
  wire [EW-1:0]   top     = stk[top_idx];
  wire            top_hi  = top[PC_W];

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = flags;
      2'd1:    reg_rdata = en;
      2'd2:    reg_rdata = pri;
      default: reg_rdata = N_SRC'({gie_h, gie_l});
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
      pri   <= '0;
    end else begin
      flags <= (wr_flag ? (flags & reg_wdata) : flags) | evt_i;
      if (wr_en)  en  <= reg_wdata;
      if (wr_pri) pri <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_h <= '0;
      sr_l <= '0;
    end else begin
      sr_h <= (sr_h << 1) | LATENCY'(req_h);
      sr_l <= (sr_l << 1) | LATENCY'(req_l);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_h <= 1'b0;
      gie_l <= 1'b0;
    end else begin
      if (wr_gie) begin
        gie_h <= reg_wdata[1];
        gie_l <= reg_wdata[0];
      end
      if (fire_h) gie_h <= 1'b0;
      if (fire_l) gie_l <= 1'b0;
      if (pop) begin
        if (top_hi) gie_h <= 1'b1;
        else        gie_l <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take_o) stk[sp[AW-1:0]] <= {fire_h, pc_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp       <= '0;
      act_hi   <= '0;
      boot_q   <= 1'b1;
      ret_q    <= 1'b0;
      ret_pc_q <= '0;
    end else begin
      boot_q <= 1'b0;
      ret_q  <= pop;
      if (pop) ret_pc_q <= top[PC_W-1:0];
      if (take_o)   sp <= sp + SPW'(1);
      else if (pop) sp <= sp - SPW'(1);
      if (fire_h)             act_hi <= act_hi + SPW'(1);
      else if (pop && top_hi) act_hi <= act_hi - SPW'(1);
    end
  end

  a_r4_vector: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (vec_o == PC_W'(8) || vec_o == PC_W'(24)));
  a_r3_pending: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (|pend_o));
  a_r7_push: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> sp == $past(sp) + SPW'(1));
  a_r7_low_gie_off: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == PC_W'(24)) |=> !gie_l);
  a_r8_low_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == PC_W'(24)) |-> act_hi == '0);
  a_r9_pop: assert property (@(posedge clk) disable iff (!rst_n)
    ret_o |-> sp == $past(sp) - SPW'(1));
  a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(STK_DEPTH));
  a_r5_boot: assert property (@(posedge clk) disable iff (!rst_n)
    boot_o |-> (vec_o == '0 && !take_o));
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int N = 8, PW = 21, D = 32, LAT = 2;

  logic clk = 0, rst_n = 0, reg_we = 0, reti_i = 0;
  logic [N-1:0] evt_i = '0, reg_wdata = '0, reg_rdata, pend_o;
  logic [1:0] reg_addr = '0;
  logic [PW-1:0] pc_i = '0, vec_o, ret_pc_o;
  logic boot_o, take_o, ret_o;

  irq_vector_ctrl #(.N_SRC(N), .PC_W(PW), .STK_DEPTH(D), .LATENCY(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pc_i(pc_i), .reti_i(reti_i),
    .boot_o(boot_o), .take_o(take_o), .vec_o(vec_o), .ret_o(ret_o),
    .ret_pc_o(ret_pc_o), .pend_o(pend_o));

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [PW:0] expq [$];
  logic [PW:0] mon_e;
  logic [N-1:0] v;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (take_o) begin
        if (expq.size() == 0) chk(0, "R3 no take expected", {11'd0, vec_o}, 0);
        else begin
          mon_e = expq.pop_front();
          chk(mon_e == {1'b1, vec_o}, "R4 take vector", {10'd0, 1'b1, vec_o}, {10'd0, mon_e});
        end
      end
      if (ret_o) begin
        if (expq.size() == 0) chk(0, "R9 no return expected", {11'd0, ret_pc_o}, 0);
        else begin
          mon_e = expq.pop_front();
          chk(mon_e == {1'b0, ret_pc_o}, "R9 return address", {10'd0, 1'b0, ret_pc_o}, {10'd0, mon_e});
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask
  task automatic pulse(input logic [N-1:0] m);
    evt_i = m;
    tick(1);
    evt_i = '0;
  endtask
  task automatic ret_cmd();
    reti_i = 1;
    tick(1);
    reti_i = 0;
  endtask
  task automatic exp_take(input logic [PW-1:0] a);
    expq.push_back({1'b1, a});
  endtask
  task automatic exp_ret(input logic [PW-1:0] a);
    expq.push_back({1'b0, a});
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    #1 chk(boot_o == 1 && vec_o == '0 && !take_o, "R5 boot vector", {boot_o, vec_o}, {1'b1, 21'h0});
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk(v == '0, "R5 reset register", v, 0);
    end
    tick(1);
    #1 chk(boot_o == 0, "R5 boot pulse ends", boot_o, 0);

    // R1 / R3: flag without enable
    tick(1);
    pulse(8'h08);
    rd(0, v); chk(v == 8'h08, "R1 flag latched while disabled", v, 8'h08);
    chk(pend_o == '0, "R3 pend needs enable", pend_o, 0);
    tick(1); wr(3, 8'h03); tick(5);
    // R2: write-1 no effect, set wins over clear
    wr(0, 8'hFF);
    rd(0, v); chk(v == 8'h08, "R2 write 1 no effect", v, 8'h08);
    tick(1);
    evt_i = 8'h04; reg_we = 1; reg_addr = 0; reg_wdata = 8'h00;
    tick(1);
    evt_i = '0; reg_we = 0;
    rd(0, v); chk(v == 8'h04, "R2 set wins over clear", v, 8'h04);
    tick(1); wr(0, 8'h00);
    rd(0, v); chk(v == 8'h00, "R2 clear by 0", v, 0);

    // R6 / R7: low take timing
    tick(1);
    wr(2, 8'h20); wr(1, 8'h22);
    pc_i = 21'h01234;
    exp_take(21'h18);
    pulse(8'h02);
    #1 chk(!take_o, "R6 no take at edge 0", take_o, 0);
    tick(1); #1 chk(!take_o, "R6 no take at edge 1", take_o, 0);
    tick(1); #1 chk(take_o && vec_o == 21'h18, "R6 take at edge 2", {take_o, vec_o}, {1'b1, 21'h18});
    tick(1); #1 chk(!take_o, "R7 single cycle take", take_o, 0);
    rd(3, v); chk(v == 8'h02, "R7 low enable cleared", v, 2);
    tick(1); wr(0, 8'hFD);

    // R8: high preempts low
    pc_i = 21'h0ABCD;
    exp_take(21'h08);
    pulse(8'h20);
    tick(4);
    rd(3, v); chk(v == 8'h00, "R8 high taken inside low handler", v, 0);
    tick(1); wr(0, 8'hDF);
    exp_ret(21'h0ABCD);
    ret_cmd(); tick(1);
    rd(3, v); chk(v == 8'h02, "R9 high enable restored", v, 2);
    tick(1);
    exp_ret(21'h01234);
    ret_cmd(); tick(1);
    rd(3, v); chk(v == 8'h03, "R9 low enable restored", v, 3);

    // R8: both pending, high first, low waits
    tick(1);
    pc_i = 21'h22222;
    exp_take(21'h08);
    pulse(8'h22);
    tick(6);
    #1 chk(pend_o == 8'h22, "R11 pend lists both", pend_o, 8'h22);
    rd(3, v); chk(v == 8'h01, "R8 low held during high handler", v, 1);
    tick(1); wr(0, 8'hDF);
    pc_i = 21'h33333;
    exp_ret(21'h22222);
    exp_take(21'h18);
    ret_cmd(); tick(5);
    wr(0, 8'hFD);
    exp_ret(21'h33333);
    ret_cmd(); tick(2);

    // R11: two low sources, one take
    wr(1, 8'h26);
    pc_i = 21'h44444;
    exp_take(21'h18);
    pulse(8'h06);
    tick(6);
    #1 chk(pend_o == 8'h06, "R11 pend lists all low", pend_o, 8'h06);
    tick(1); wr(0, 8'hF9);
    exp_ret(21'h44444);
    ret_cmd(); tick(2);

    // R9: return with empty stack
    ret_cmd(); tick(3);
    rd(3, v); chk(v == 8'h03, "R9 empty return no effect", v, 3);

    // R10: fill the stack
    tick(1); wr(1, 8'h02);
    for (int i = 0; i < D; i++) begin
      pc_i = PW'(100 + i);
      exp_take(21'h18);
      if (i == 0) pulse(8'h02);
      else wr(3, 8'h03);
      tick(4);
    end
    wr(3, 8'h03); tick(8);
    rd(3, v); chk(v == 8'h03, "R10 no take when full", v, 3);
    tick(1); wr(0, 8'h00);
    for (int i = 0; i < D; i++) begin
      exp_ret(PW'(100 + D - 1 - i));
      ret_cmd(); tick(1);
    end
    tick(3);
    chk(expq.size() == 0, "R9 scoreboard drained", expq.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule